// File: doc/BRIEF.md
# Hardware Debug Breakpoint Unit

This block is the debug unit of a processor core. It keeps four breakpoint address registers, a control register and a status register. Each cycle it receives at most one access event, either an instruction fetch or a data access. A data access carries its size, its direction, and whether it goes to I/O space or to memory. The unit compares the event against all four breakpoints. It records every qualifying match in the status register, and it raises a one-cycle debug-exception pulse when a match belongs to an enabled breakpoint.

The unit also generates single-step traps from the trap-flag level and the retire strobe. It suppresses instruction breakpoints while the resume flag is set, so a handler can return to the faulting address without trapping again at once. When general-detect is armed, it traps any register access. Registers are read and written only through a privileged register port. The pipeline, exception vectoring and flag storage are outside the block.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After reset:
  - every breakpoint address and the control register read 0;
  - the status register reads 0xFFFF1FF0;
  - `dbg_exc` and `rf_q` are 0.
- R2: Register port behaviour:
  - Select codes: 0 to 3 pick breakpoint addresses 0 to 3, 6 picks status and 7 picks control.
  - Reads are combinational. Writes take effect at the clock edge.
  - Control keeps only bits 0-9, 13 and 16-31 (mask 0xFFFF23FF); all other control bits read 0.
  - Selects 4 and 5 read 0, and writes to them are ignored.
  - Status bits 4-12 and 16-31 always read 1.
- R3: Control layout for breakpoint n:
  - bit 2n is the local enable and bit 2n+1 is the global enable;
  - bits 17+4n:16+4n hold the access type;
  - bits 19+4n:18+4n hold the length.
  - A qualifying match sets status bit n whether or not the breakpoint is enabled. Only an enabled breakpoint raises `dbg_exc`.
- R4: Access-type codes:
  - 00 matches instruction fetches only;
  - 01 matches memory data writes only;
  - 11 matches memory data reads and writes, never fetches;
  - 10 matches I/O data accesses only when `dext_en` is 1, and never otherwise.
- R5: Length and overlap:
  - Length code 00 covers 1 byte, 01 covers 2 bytes and 11 covers 4 bytes. The low address bits are ignored, so the range is aligned to its length. Code 10 never matches.
  - A fetch covers 1 byte at `ev_addr`. A data access covers `ev_size`+1 bytes starting at `ev_addr`.
  - A match requires the access range and the breakpoint range to overlap.
- R6: `dbg_exc` is high for exactly the one cycle after the clock edge that samples the triggering event. The status update becomes visible at the same time.
- R7: Status bits 0-3 and 13-15 are sticky and change only through a software write. If a hardware set and a software write hit the same bit in the same cycle, the hardware set wins.
- R8: On a retire, a single-step trap fires when `tf` was 1 at the previous retire. The trap raises `dbg_exc` and sets status bit 14. The retire that first sets `tf` does not trap.
- R9: Resume flag behaviour:
  - `rf_set` sets `rf_q`.
  - While `rf_q` is 1, a fetch neither raises `dbg_exc` nor sets status bits 0-3.
  - `rf_q` clears on the next `ev_retire`, unless `rf_set` is high in that same cycle.
- R10: When control bit 13 (general-detect) is 1, any register-port access is dropped. The unit then raises `dbg_exc`, sets status bit 13 and clears control bit 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dext_en | input | 1 | Debug-extensions enable: allows I/O breakpoints |
| reg_en | input | 1 | Privileged register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| ev_valid | input | 1 | An access event is present |
| ev_fetch | input | 1 | Event is an instruction fetch |
| ev_write | input | 1 | Data event is a write |
| ev_io | input | 1 | Data event targets I/O space |
| ev_addr | input | 32 | Linear address of the event |
| ev_size | input | 2 | Data access bytes minus one |
| ev_retire | input | 1 | An instruction completes this cycle |
| tf | input | 1 | Trap flag after the retiring instruction |
| rf_set | input | 1 | Sets the resume flag |
| rf_q | output | 1 | Current resume flag |
| dbg_exc | output | 1 | Debug exception pulse |

## Verification
The effects of internal state faults on the ports differ by fault:
- A corrupted breakpoint field or a misplaced mask shows one cycle after the offending event. Either `dbg_exc` is missing or spurious, or the status read-back disagrees.
- A lost step-arm bit shows only at the second retire after `tf` rises, so that timing is checked retire by retire.
- A resume flag that clears too early or too late shows on the first fetch to the breakpointed address after `rf_set`.
- A sticky bit that leaks away shows on the next status read.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    localparam int NUM_BP = 4;
    localparam int AW     = 32;
    localparam int SEL_W  = 3;

    localparam logic [SEL_W-1:0] SEL_STAT = 3'd6;
    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd7;

    localparam int CTRL_GD_BIT  = 13;
    localparam int STAT_GD_BIT  = 13;
    localparam int STAT_SS_BIT  = 14;

    localparam logic [AW-1:0] CTRL_KEEP = 32'hFFFF_23FF;
    localparam logic [AW-1:0] STAT_RW   = 32'h0000_E00F;
    localparam logic [AW-1:0] STAT_ONES = 32'hFFFF_1FF0;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_WR    = 2'b01,
        ACC_IO    = 2'b10,
        ACC_RW    = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic          valid;
        logic          fetch;
        logic          write;
        logic          io;
        logic [AW-1:0] addr;
        logic [1:0]    size;
    } dbg_event_t;

    // Bytes covered minus one for a length code; code 10 is filtered elsewhere.
    function automatic logic [1:0] span_of(input logic [1:0] len);
        case (len)
            2'b01:   return 2'd1;
            2'b11:   return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/dbg_cmp.sv
module dbg_cmp
    import dbg_pkg::*;
(
    input  dbg_event_t    ev,
    input  logic [AW-1:0] bp_addr,
    input  logic [1:0]    kind,
    input  logic [1:0]    len,
    input  logic          dext_en,
    output logic          hit
);
    logic [1:0]  sp;
    logic [AW:0] b_lo, b_hi, a_lo, a_hi;
    logic        kind_ok;

    always_comb begin
        sp   = span_of(len);
        b_lo = {1'b0, bp_addr & ~{{(AW-2){1'b0}}, sp}};
        b_hi = b_lo + {{(AW-1){1'b0}}, sp};
        a_lo = {1'b0, ev.addr};
        a_hi = a_lo + (ev.fetch ? '0 : {{(AW-1){1'b0}}, ev.size});

        unique case (acc_kind_e'(kind))
            ACC_FETCH: kind_ok = ev.fetch;
            ACC_WR:    kind_ok = !ev.fetch && !ev.io && ev.write;
            ACC_RW:    kind_ok = !ev.fetch && !ev.io;
            ACC_IO:    kind_ok = dext_en && !ev.fetch && ev.io;
        endcase

        hit = ev.valid && kind_ok && (len != 2'b10) &&
              (a_lo <= b_hi) && (b_lo <= a_hi);
    end
endmodule

// File: rtl/dbg_step.sv
module dbg_step (
    input  logic clk,
    input  logic rst,
    input  logic retire,
    input  logic tf,
    input  logic rf_set,
    output logic step_trap,
    output logic rf_q
);
    logic armed_q;

    assign step_trap = retire && armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            rf_q    <= 1'b0;
        end else begin
            if (retire)
                armed_q <= tf;
            if (rf_set)
                rf_q <= 1'b1;
            else if (retire)
                rf_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_regs.sv
module dbg_regs
    import dbg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       reg_en,
    input  logic                       reg_we,
    input  logic [SEL_W-1:0]           reg_sel,
    input  logic [AW-1:0]              reg_wdata,
    input  logic [NUM_BP-1:0]          set_match,
    input  logic                       set_step,
    output logic [AW-1:0]              reg_rdata,
    output logic                       gd_trip,
    output logic [NUM_BP-1:0][AW-1:0]  bp_addr,
    output logic [AW-1:0]              ctrl,
    output logic [AW-1:0]              stat
);
    logic          wr_ok;
    logic [AW-1:0] stat_set, stat_next;

    assign gd_trip = reg_en && ctrl[CTRL_GD_BIT];
    assign wr_ok   = reg_en && reg_we && !ctrl[CTRL_GD_BIT];

    always_comb begin
        stat_set              = '0;
        stat_set[NUM_BP-1:0]  = set_match;
        stat_set[STAT_GD_BIT] = gd_trip;
        stat_set[STAT_SS_BIT] = set_step;
        stat_next = (wr_ok && reg_sel == SEL_STAT) ? (reg_wdata & STAT_RW) : stat;
        stat_next = stat_next | stat_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bp_addr <= '0;
            ctrl    <= '0;
            stat    <= '0;
        end else begin
            for (int n = 0; n < NUM_BP; n++)
                if (wr_ok && reg_sel == SEL_W'(n))
                    bp_addr[n] <= reg_wdata;
            if (gd_trip)
                ctrl[CTRL_GD_BIT] <= 1'b0;
            else if (wr_ok && reg_sel == SEL_CTRL)
                ctrl <= reg_wdata & CTRL_KEEP;
            stat <= stat_next;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel < SEL_W'(NUM_BP))
            reg_rdata = bp_addr[reg_sel[1:0]];
        else if (reg_sel == SEL_STAT)
            reg_rdata = stat | STAT_ONES;
        else if (reg_sel == SEL_CTRL)
            reg_rdata = ctrl;
    end
endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
    import dbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dext_en,
    input  logic             reg_en,
    input  logic             reg_we,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [AW-1:0]    reg_wdata,
    output logic [AW-1:0]    reg_rdata,
    input  logic             ev_valid,
    input  logic             ev_fetch,
    input  logic             ev_write,
    input  logic             ev_io,
    input  logic [AW-1:0]    ev_addr,
    input  logic [1:0]       ev_size,
    input  logic             ev_retire,
    input  logic             tf,
    input  logic             rf_set,
    output logic             rf_q,
    output logic             dbg_exc
);
    dbg_event_t               ev;
    logic [NUM_BP-1:0][AW-1:0] bp_addr_w;
    logic [AW-1:0]            ctrl_w, stat_w;
    logic [NUM_BP-1:0]        hit_vec, en_vec, qual_vec;
    logic                     gd_trip, step_trap, suppress, exc_d, exc_q;

    assign ev = '{valid: ev_valid, fetch: ev_fetch, write: ev_write,
                  io: ev_io, addr: ev_addr, size: ev_size};

    for (genvar n = 0; n < NUM_BP; n++) begin : g_bp
        dbg_cmp u_cmp (
            .ev      (ev),
            .bp_addr (bp_addr_w[n]),
            .kind    (ctrl_w[16+4*n +: 2]),
            .len     (ctrl_w[18+4*n +: 2]),
            .dext_en (dext_en),
            .hit     (hit_vec[n])
        );
        assign en_vec[n] = ctrl_w[2*n] | ctrl_w[2*n+1];
    end

    assign suppress = rf_q && ev_fetch;
    assign qual_vec = hit_vec & {NUM_BP{!suppress}};

    dbg_step u_step (
        .clk       (clk),
        .rst       (rst),
        .retire    (ev_retire),
        .tf        (tf),
        .rf_set    (rf_set),
        .step_trap (step_trap),
        .rf_q      (rf_q)
    );

    dbg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .set_match (qual_vec),
        .set_step  (step_trap),
        .reg_rdata (reg_rdata),
        .gd_trip   (gd_trip),
        .bp_addr   (bp_addr_w),
        .ctrl      (ctrl_w),
        .stat      (stat_w)
    );

    assign exc_d = (|(qual_vec & en_vec)) || step_trap || gd_trip;

    always_ff @(posedge clk) begin
        if (rst) exc_q <= 1'b0;
        else     exc_q <= exc_d;
    end

    assign dbg_exc = exc_q;
endmodule

// File: rtl/dbg_bkpt_chk.sv
module dbg_bkpt_chk
    import dbg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             reg_en,
    input logic             reg_we,
    input logic [SEL_W-1:0] reg_sel,
    input logic [AW-1:0]    reg_rdata,
    input logic             ev_retire,
    input logic             rf_set,
    input logic             rf_q,
    input logic             dbg_exc,
    input logic             step_trap,
    input logic             ctrl_gd,
    input logic [AW-1:0]    stat
);
    // R2
    stat_ones_chk: assert property (@(posedge clk) disable iff (rst)
        reg_en && !reg_we && reg_sel == SEL_STAT |-> (reg_rdata & STAT_ONES) == STAT_ONES);

    // R7
    match_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_en && reg_we && reg_sel == SEL_STAT && !ctrl_gd)
        |=> (stat[3:0] & $past(stat[3:0])) == $past(stat[3:0]));

    // R8
    step_trap_chk: assert property (@(posedge clk) disable iff (rst)
        step_trap |=> dbg_exc && stat[STAT_SS_BIT]);

    // R9
    rf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rf_q && ev_retire && !rf_set |=> !rf_q);

    // R9
    rf_set_chk: assert property (@(posedge clk) disable iff (rst)
        rf_set |=> rf_q);

    // R10
    gd_trip_chk: assert property (@(posedge clk) disable iff (rst)
        reg_en && ctrl_gd |=> dbg_exc && stat[STAT_GD_BIT] && !ctrl_gd);
endmodule

bind dbg_bkpt_unit dbg_bkpt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata),
    .ev_retire (ev_retire),
    .rf_set    (rf_set),
    .rf_q      (rf_q),
    .dbg_exc   (dbg_exc),
    .step_trap (step_trap),
    .ctrl_gd   (ctrl_w[13]),
    .stat      (stat_w)
);

// File: tb/sim_dbg_bkpt_unit.sv
module sim_dbg_bkpt_unit;
    localparam int CLK_P = 10;
    localparam int NV    = 20;
    localparam logic [31:0] ST_BASE = 32'hFFFF_1FF0;

    // {ctrl, bp0, fetch/write/io, addr, size, dext, exp_status_bit0, exp_exc}
    localparam logic [103:0] VEC [NV] = '{
        {32'h0000_0001, 32'h0000_1000, 3'b100, 32'h0000_1000, 2'd0, 1'b0, 1'b1, 1'b1}, // R4 fetch hit
        {32'h0000_0001, 32'h0000_1000, 3'b100, 32'h0000_1001, 2'd0, 1'b0, 1'b0, 1'b0}, // R5 miss
        {32'h0000_0000, 32'h0000_1000, 3'b100, 32'h0000_1000, 2'd0, 1'b0, 1'b1, 1'b0}, // R3 disabled
        {32'h0000_0002, 32'h0000_1000, 3'b100, 32'h0000_1000, 2'd0, 1'b0, 1'b1, 1'b1}, // R3 global
        {32'h0001_0001, 32'h0000_2000, 3'b010, 32'h0000_2000, 2'd0, 1'b0, 1'b1, 1'b1}, // R4 write
        {32'h0001_0001, 32'h0000_2000, 3'b000, 32'h0000_2000, 2'd0, 1'b0, 1'b0, 1'b0}, // R4 read on wr-only
        {32'h0001_0001, 32'h0000_2000, 3'b100, 32'h0000_2000, 2'd0, 1'b0, 1'b0, 1'b0}, // R4 fetch on wr-only
        {32'h0003_0001, 32'h0000_2000, 3'b000, 32'h0000_2000, 2'd0, 1'b0, 1'b1, 1'b1}, // R4 read on rw
        {32'h0003_0001, 32'h0000_2000, 3'b100, 32'h0000_2000, 2'd0, 1'b0, 1'b0, 1'b0}, // R4 fetch on rw
        {32'h000F_0001, 32'h0000_3002, 3'b000, 32'h0000_3003, 2'd0, 1'b0, 1'b1, 1'b1}, // R5 len4 top
        {32'h000F_0001, 32'h0000_3002, 3'b000, 32'h0000_3004, 2'd0, 1'b0, 1'b0, 1'b0}, // R5 len4 past
        {32'h000F_0001, 32'h0000_3002, 3'b000, 32'h0000_2FFE, 2'd3, 1'b0, 1'b1, 1'b1}, // R5 overlap
        {32'h0007_0001, 32'h0000_4001, 3'b000, 32'h0000_4002, 2'd0, 1'b0, 1'b0, 1'b0}, // R5 len2 past
        {32'h0007_0001, 32'h0000_4001, 3'b000, 32'h0000_4000, 2'd0, 1'b0, 1'b1, 1'b1}, // R5 len2 align
        {32'h000B_0001, 32'h0000_5000, 3'b000, 32'h0000_5000, 2'd0, 1'b0, 1'b0, 1'b0}, // R5 len code 10
        {32'h0002_0001, 32'h0000_0060, 3'b001, 32'h0000_0060, 2'd0, 1'b0, 1'b0, 1'b0}, // R4 io no dext
        {32'h0002_0001, 32'h0000_0060, 3'b001, 32'h0000_0060, 2'd0, 1'b1, 1'b1, 1'b1}, // R4 io dext
        {32'h0002_0001, 32'h0000_0060, 3'b000, 32'h0000_0060, 2'd0, 1'b1, 1'b0, 1'b0}, // R4 mem on io
        {32'h0001_0001, 32'h0000_2000, 3'b010, 32'h0000_1FFF, 2'd1, 1'b0, 1'b1, 1'b1}, // R5 2-byte cross
        {32'h0003_0001, 32'h0000_2000, 3'b011, 32'h0000_2000, 2'd0, 1'b0, 1'b0, 1'b0}  // R4 io on rw
    };

    logic        clk = 1'b0, rst = 1'b1;
    logic        dext_en = 0, reg_en = 0, reg_we = 0;
    logic [2:0]  reg_sel = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        ev_valid = 0, ev_fetch = 0, ev_write = 0, ev_io = 0;
    logic [31:0] ev_addr = 0;
    logic [1:0]  ev_size = 0;
    logic        ev_retire = 0, tf = 0, rf_set = 0, rf_q, dbg_exc;
    int          n_chk = 0, n_fail = 0;
    logic [31:0] d;

    always #(CLK_P/2) clk = ~clk;

    dbg_bkpt_unit u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_en = 1; reg_we = 1; reg_sel = sel; reg_wdata = data;
        @(posedge clk); #1;
        reg_en = 0; reg_we = 0;
    endtask

    task automatic reg_rd(input logic [2:0] sel, output logic [31:0] data);
        @(negedge clk);
        reg_en = 1; reg_we = 0; reg_sel = sel;
        #1 data = reg_rdata;
        @(posedge clk); #1;
        reg_en = 0;
    endtask

    task automatic ev_do(input logic v, input logic [2:0] fwi, input logic [31:0] a,
                         input logic [1:0] sz, input logic ret);
        @(negedge clk);
        ev_valid = v; {ev_fetch, ev_write, ev_io} = fwi; ev_addr = a; ev_size = sz;
        ev_retire = ret;
        @(posedge clk); #1;
        ev_valid = 0; ev_retire = 0;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            reg_rd(3'(s), d); check("R1 bp addr", d, 32'h0);
        end
        reg_rd(3'd6, d); check("R1 status", d, ST_BASE);
        reg_rd(3'd7, d); check("R1 ctrl", d, 32'h0);
        check("R1 exc", {31'b0, dbg_exc}, 32'h0);
        check("R1 rf", {31'b0, rf_q}, 32'h0);

        // R2 register port
        reg_wr(3'd7, 32'hFFFF_DFFF);
        reg_rd(3'd7, d); check("R2 ctrl mask", d, 32'hFFFF_03FF);
        reg_wr(3'd7, 32'h0);
        reg_wr(3'd4, 32'h1234);
        reg_rd(3'd4, d); check("R2 sel4", d, 32'h0);
        reg_rd(3'd5, d); check("R2 sel5", d, 32'h0);
        reg_wr(3'd2, 32'hCAFE_0002);
        reg_rd(3'd2, d); check("R2 bp2", d, 32'hCAFE_0002);

        // R3 R4 R5 R6 table walk
        for (int i = 0; i < NV; i++) begin
            reg_wr(3'd7, VEC[i][103:72]);
            reg_wr(3'd0, VEC[i][71:40]);
            reg_wr(3'd6, 32'h0);
            dext_en = VEC[i][2];
            ev_do(1'b1, VEC[i][39:37], VEC[i][36:5], VEC[i][4:3], 1'b0);
            check($sformatf("R6 exc vec %0d", i), {31'b0, dbg_exc}, {31'b0, VEC[i][0]});
            reg_rd(3'd6, d);
            check($sformatf("R3 status vec %0d", i), d, ST_BASE | {31'b0, VEC[i][1]});
            dext_en = 0;
        end

        // R3 field positions of breakpoint 3; R6 pulse width
        reg_wr(3'd6, 32'h0);
        reg_wr(3'd7, 32'h1000_0040);
        reg_wr(3'd3, 32'h0000_7000);
        ev_do(1'b1, 3'b010, 32'h7000, 2'd0, 1'b0);
        check("R3 bp3 exc", {31'b0, dbg_exc}, 32'h1);
        @(posedge clk); #1;
        check("R6 one cycle", {31'b0, dbg_exc}, 32'h0);
        reg_rd(3'd6, d); check("R3 bp3 status", d, ST_BASE | 32'h8);

        // R7 sticky status
        reg_wr(3'd7, 32'h0000_0001);
        reg_wr(3'd0, 32'h0000_1000);
        reg_wr(3'd6, 32'h0);
        ev_do(1'b1, 3'b100, 32'h1000, 2'd0, 1'b0);
        ev_do(1'b1, 3'b100, 32'h1004, 2'd0, 1'b0);
        reg_rd(3'd6, d); check("R7 sticky", d, ST_BASE | 32'h1);
        reg_wr(3'd6, 32'hFFFF_FFFF);
        reg_rd(3'd6, d); check("R7 write ones", d, 32'hFFFF_FFFF);
        reg_wr(3'd6, 32'h0);
        reg_rd(3'd6, d); check("R7 clear", d, ST_BASE);
        @(negedge clk);
        reg_en = 1; reg_we = 1; reg_sel = 3'd6; reg_wdata = 32'h0;
        ev_valid = 1; {ev_fetch, ev_write, ev_io} = 3'b100; ev_addr = 32'h1000;
        @(posedge clk); #1;
        reg_en = 0; reg_we = 0; ev_valid = 0;
        reg_rd(3'd6, d); check("R7 hw set wins", d, ST_BASE | 32'h1);

        // R8 single step
        reg_wr(3'd7, 32'h0);
        reg_wr(3'd6, 32'h0);
        tf = 1;
        ev_do(1'b0, 3'b000, 32'h0, 2'd0, 1'b1);
        check("R8 no trap on setting retire", {31'b0, dbg_exc}, 32'h0);
        ev_do(1'b0, 3'b000, 32'h0, 2'd0, 1'b1);
        check("R8 trap next retire", {31'b0, dbg_exc}, 32'h1);
        reg_rd(3'd6, d); check("R8 status bit14", d, ST_BASE | 32'h4000);
        tf = 0;
        ev_do(1'b0, 3'b000, 32'h0, 2'd0, 1'b1);
        check("R8 trap on clearing retire", {31'b0, dbg_exc}, 32'h1);
        ev_do(1'b0, 3'b000, 32'h0, 2'd0, 1'b1);
        check("R8 disarmed", {31'b0, dbg_exc}, 32'h0);

        // R9 resume flag
        reg_wr(3'd7, 32'h0000_0001);
        reg_wr(3'd0, 32'h0000_1000);
        reg_wr(3'd6, 32'h0);
        @(negedge clk); rf_set = 1;
        @(posedge clk); #1; rf_set = 0;
        check("R9 rf set", {31'b0, rf_q}, 32'h1);
        ev_do(1'b1, 3'b100, 32'h1000, 2'd0, 1'b0);
        check("R9 fetch suppressed", {31'b0, dbg_exc}, 32'h0);
        reg_rd(3'd6, d); check("R9 no status", d, ST_BASE);
        ev_do(1'b0, 3'b000, 32'h0, 2'd0, 1'b1);
        check("R9 rf cleared", {31'b0, rf_q}, 32'h0);
        ev_do(1'b1, 3'b100, 32'h1000, 2'd0, 1'b0);
        check("R9 fetch after clear", {31'b0, dbg_exc}, 32'h1);
        @(negedge clk); rf_set = 1; ev_retire = 1;
        @(posedge clk); #1; rf_set = 0; ev_retire = 0;
        check("R9 set beats retire", {31'b0, rf_q}, 32'h1);
        ev_do(1'b0, 3'b000, 32'h0, 2'd0, 1'b1);
        check("R9 cleared later", {31'b0, rf_q}, 32'h0);

        // R10 general detect
        reg_wr(3'd6, 32'h0);
        reg_wr(3'd7, 32'h0000_2000);
        reg_wr(3'd0, 32'h0000_ABCD);
        check("R10 exc", {31'b0, dbg_exc}, 32'h1);
        reg_rd(3'd7, d); check("R10 gd cleared", d, 32'h0);
        reg_rd(3'd0, d); check("R10 write dropped", d, 32'h0000_1000);
        reg_rd(3'd6, d); check("R10 status bit13", d, ST_BASE | 32'h2000);

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule